// File: doc/BRIEF.md
# Configurable UART Receive Framer

This block watches a single asynchronous serial line that rests high and turns what it sees into received words. A frame opens with a low start bit, then carries five to nine data bits. An optional parity bit may follow, and a single high stop bit closes the frame. All bit timing comes from a 16-bit clock-cycles-per-bit input. The block times every bit from the falling edge that opened the frame and samples each bit at its centre.

The receiver configuration is set at run time: word width, whether the first data bit on the line is the least or the most significant, one of five parity modes, and whether parity mismatches are reported. These settings are captured only while the block is idle, so changing them mid-frame has no effect on the frame in progress. Each completed frame produces a one-cycle strobe together with the word and three error flags: a start bit that was not low at its centre, a parity mismatch, and a stop bit that was not high.

Top module: `uart_rx_framer`

## Requirements
- R1: After synchronous reset, `rx_valid`, `rx_data` and all three error flags read 0, and a line that stays high produces no strobe.
- R2: A frame starts only on a high-to-low transition of the synchronized line while idle. The line passes through a two-flop synchronizer, and the falling edge becomes known to the control logic one cycle after that.
- R3: Bit n of a frame, with 0 being the start bit, is sampled `3 + floor(P/2) + n*P` clock edges after the first edge that sees the line low, where P is `cfg_cycles_per_bit` (at least 4). The result is visible right after the stop-bit sample edge.
- R4: `cfg_data_bits` selects 5 to 9 data bits. The word is right-aligned in `rx_data`, and the bits above the width read 0.
- R5: With `cfg_msb_first` = 0 the first data bit on the line becomes `rx_data[0]`. With `cfg_msb_first` = 1 it becomes `rx_data[N-1]`.
- R6: `cfg_parity_mode` encodes 0 none, 1 odd, 2 even, 3 forced zero and 4 forced one; codes 5 to 7 act as none. Odd and even judge the number of ones in data plus parity bit. Forced modes require the parity bit to equal 0 or 1.
- R7: With parity none there is no parity slot, and the stop bit is bit index N+1 instead of N+2.
- R8: A start bit sampled high sets `err_start` but the rest of the frame is still received and delivered.
- R9: A stop bit sampled low sets `err_frame`. In either case the block then waits idle for the next falling edge.
- R10: With `cfg_parity_check` = 0 a parity mismatch does not set `err_parity`, but the parity slot is still consumed.
- R11: Configuration inputs are captured only while idle. Changes during a frame do not affect that frame.
- R12: `rx_valid` is high for exactly one cycle per frame, and `rx_data` and the error flags change in that same cycle. The flags read 0 when `rx_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_serial | input | 1 | Asynchronous serial line, idles high |
| cfg_cycles_per_bit | input | 16 | Clock cycles per bit period (4 or more) |
| cfg_data_bits | input | 4 | Data width 5..9 (clamped into that range) |
| cfg_msb_first | input | 1 | 1: first data bit is the most significant |
| cfg_parity_mode | input | 3 | 0 none, 1 odd, 2 even, 3 zero, 4 one |
| cfg_parity_check | input | 1 | 1: report parity mismatches |
| rx_data | output | 9 | Received word, right-aligned |
| rx_valid | output | 1 | One-cycle strobe for a completed frame |
| err_start | output | 1 | Start bit was high at its centre |
| err_parity | output | 1 | Parity bit mismatched the selected mode |
| err_frame | output | 1 | Stop bit was low at its centre |

## Verification
Every result is due a fixed number of cycles after the stimulus. For a frame whose line falls just before edge 1, the strobe is due after edge `3 + floor(P/2) + S*P`, where S is the stop-bit index N+1 or N+2. The bench counts clock edges from the cycle in which it drives the line low and records the edge count at which the strobe appears. It compares that count with the formula for every frame, so both the bit-centre arithmetic and the parity-slot skip are pinned to the exact cycle. It also samples outputs on the falling clock edge, counts how many strobes a frame produced, and allows three idle bit periods before it judges a frame.

// File: rtl/urx_pkg.sv
package urx_pkg;

  typedef enum logic [2:0] {
    PAR_NONE = 3'd0,
    PAR_ODD  = 3'd1,
    PAR_EVEN = 3'd2,
    PAR_ZERO = 3'd3,
    PAR_ONE  = 3'd4
  } parity_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } rx_state_e;

  function automatic parity_e decode_parity(input logic [2:0] code);
    case (code)
      3'd1:    return PAR_ODD;
      3'd2:    return PAR_EVEN;
      3'd3:    return PAR_ZERO;
      3'd4:    return PAR_ONE;
      default: return PAR_NONE;
    endcase
  endfunction

endpackage

// File: rtl/urx_line_sync.sv
module urx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic line,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= 1'b1;
    else     chain[0] <= din;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[g] <= 1'b1;
      else     chain[g] <= chain[g-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b1;
    else     prev <= chain[STAGES-1];
  end

  assign line = chain[STAGES-1];
  assign fall = prev & ~chain[STAGES-1];

  // R2: a falling edge cannot repeat on consecutive cycles
  assert_fall_single_R2: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall);
endmodule

// File: rtl/urx_bit_timer.sv
module urx_bit_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_half,
  input  logic          run,
  input  logic [CW-1:0] period,
  output logic          tick
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load_half) begin
      cnt <= (period >> 1) - CW'(1);
    end else if (run) begin
      if (cnt == '0) cnt <= period - CW'(1);
      else           cnt <= cnt - CW'(1);
    end
  end

  assign tick = run && (cnt == '0);

  // R3: while running, the countdown never reaches a full period
  assert_cnt_in_period_R3: assert property (@(posedge clk) disable iff (rst)
    (run && !load_half && period >= CW'(4) && $stable(period) && $past(run)) |-> (cnt < period));
endmodule

// File: rtl/urx_shift_asm.sv
module urx_shift_asm #(
  parameter int W    = 9,
  parameter int NB_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic            shift_en,
  input  logic            msb_first,
  input  logic [NB_W-1:0] nbits,
  input  logic            bit_in,
  output logic [W-1:0]    word
);
  logic [W-1:0] nxt;

  always_comb begin
    if (msb_first) begin
      nxt = {word[W-2:0], bit_in};
    end else begin
      nxt = word >> 1;
      nxt[nbits - NB_W'(1)] = bit_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) word <= '0;
    else if (shift_en) word <= nxt;
  end

  // R4: bits at or above the selected width stay zero while shifting
  assert_upper_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !clear && $stable(nbits)) |=> ((word >> nbits) == '0));
endmodule

// File: rtl/urx_parity_judge.sv
module urx_parity_judge #(
  parameter int W = 9
) (
  input  urx_pkg::parity_e mode,
  input  logic [W-1:0]     word,
  input  logic             pbit,
  output logic             ok
);
  import urx_pkg::*;
  logic odd_total;

  assign odd_total = ^{word, pbit};

  always_comb begin
    case (mode)
      PAR_ODD:  ok = odd_total;
      PAR_EVEN: ok = !odd_total;
      PAR_ZERO: ok = !pbit;
      PAR_ONE:  ok = pbit;
      default:  ok = 1'b1;
    endcase
  end
endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer #(
  parameter int CPB_W       = 16,
  parameter int MIN_DATA    = 5,
  parameter int MAX_DATA    = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rx_serial,
  input  logic [CPB_W-1:0]    cfg_cycles_per_bit,
  input  logic [3:0]          cfg_data_bits,
  input  logic                cfg_msb_first,
  input  logic [2:0]          cfg_parity_mode,
  input  logic                cfg_parity_check,
  output logic [MAX_DATA-1:0] rx_data,
  output logic                rx_valid,
  output logic                err_start,
  output logic                err_parity,
  output logic                err_frame
);
  import urx_pkg::*;

  localparam int NB_W = $clog2(MAX_DATA + 1);

  rx_state_e            state;
  logic [CPB_W-1:0]     period_q;
  logic [NB_W-1:0]      nbits_q;
  logic                 msb_q;
  parity_e              mode_q;
  logic                 chk_q;
  logic [NB_W-1:0]      bit_idx;
  logic                 start_bad;
  logic                 par_bad;

  logic                 line;
  logic                 fall;
  logic                 tick;
  logic                 begin_frame;
  logic [CPB_W-1:0]     period_sel;
  logic [MAX_DATA-1:0]  word;
  logic                 par_ok;
  logic [NB_W-1:0]      nbits_in;

  always_comb begin
    if (cfg_data_bits < 4'(MIN_DATA))      nbits_in = NB_W'(MIN_DATA);
    else if (cfg_data_bits > 4'(MAX_DATA)) nbits_in = NB_W'(MAX_DATA);
    else                                   nbits_in = NB_W'(cfg_data_bits);
  end

  assign begin_frame = (state == ST_IDLE) && fall;
  assign period_sel  = (state == ST_IDLE) ? cfg_cycles_per_bit : period_q;

  urx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (rx_serial),
    .line(line),
    .fall(fall)
  );

  urx_bit_timer #(.CW(CPB_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load_half(begin_frame),
    .run      (state != ST_IDLE),
    .period   (period_sel),
    .tick     (tick)
  );

  urx_shift_asm #(.W(MAX_DATA), .NB_W(NB_W)) u_asm (
    .clk      (clk),
    .rst      (rst),
    .clear    (begin_frame),
    .shift_en ((state == ST_DATA) && tick),
    .msb_first(msb_q),
    .nbits    (nbits_q),
    .bit_in   (line),
    .word     (word)
  );

  urx_parity_judge #(.W(MAX_DATA)) u_par (
    .mode(mode_q),
    .word(word),
    .pbit(line),
    .ok  (par_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      period_q   <= '0;
      nbits_q    <= NB_W'(MAX_DATA - 1);
      msb_q      <= 1'b0;
      mode_q     <= PAR_NONE;
      chk_q      <= 1'b0;
      bit_idx    <= '0;
      start_bad  <= 1'b0;
      par_bad    <= 1'b0;
      rx_data    <= '0;
      rx_valid   <= 1'b0;
      err_start  <= 1'b0;
      err_parity <= 1'b0;
      err_frame  <= 1'b0;
    end else begin
      rx_valid   <= 1'b0;
      err_start  <= 1'b0;
      err_parity <= 1'b0;
      err_frame  <= 1'b0;
      case (state)
        ST_IDLE: begin
          period_q <= cfg_cycles_per_bit;
          nbits_q  <= nbits_in;
          msb_q    <= cfg_msb_first;
          mode_q   <= decode_parity(cfg_parity_mode);
          chk_q    <= cfg_parity_check;
          if (fall) state <= ST_START;
        end
        ST_START: if (tick) begin
          start_bad <= line;
          par_bad   <= 1'b0;
          bit_idx   <= '0;
          state     <= ST_DATA;
        end
        ST_DATA: if (tick) begin
          bit_idx <= bit_idx + NB_W'(1);
          if (bit_idx == nbits_q - NB_W'(1))
            state <= (mode_q == PAR_NONE) ? ST_STOP : ST_PARITY;
        end
        ST_PARITY: if (tick) begin
          par_bad <= chk_q && !par_ok;
          state   <= ST_STOP;
        end
        ST_STOP: if (tick) begin
          rx_valid   <= 1'b1;
          rx_data    <= word;
          err_start  <= start_bad;
          err_parity <= par_bad;
          err_frame  <= !line;
          state      <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: leaving idle needs a falling edge
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !fall) |=> (state == ST_IDLE));

  // R7: the parity slot is never visited when parity is none
  assert_no_parity_slot_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PARITY) |-> (mode_q != PAR_NONE));

  // R8: a bad start bit does not abort the frame
  assert_start_continues_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_START && tick) |=> (state == ST_DATA));

  // R9: after the stop sample the block is idle again
  assert_back_to_idle_R9: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> (state == ST_IDLE));

  // R11: captured configuration holds while a frame is in progress
  assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |=> ($stable(nbits_q) && $stable(mode_q) && $stable(period_q)));

  // R12: the strobe lasts one cycle and follows a stop-bit state
  assert_valid_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
  assert_valid_after_stop_R12: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> ($past(state) == ST_STOP));
  assert_flags_with_valid_R12: assert property (@(posedge clk) disable iff (rst)
    (err_start || err_parity || err_frame) |-> rx_valid);

  // R6: no parity error is reported when the frame had no parity
  assert_parity_err_mode_R6: assert property (@(posedge clk) disable iff (rst)
    err_parity |-> ($past(mode_q) != PAR_NONE));
endmodule

// File: tb/tb_uart_rx_framer.sv
module tb_uart_rx_framer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_serial = 1'b1;
  logic [15:0] cfg_cycles_per_bit = 16'd16;
  logic [3:0]  cfg_data_bits = 4'd8;
  logic        cfg_msb_first = 1'b0;
  logic [2:0]  cfg_parity_mode = 3'd0;
  logic        cfg_parity_check = 1'b1;
  logic [8:0]  rx_data;
  logic        rx_valid;
  logic        err_start;
  logic        err_parity;
  logic        err_frame;

  always #5 clk = ~clk;

  uart_rx_framer dut (
    .clk(clk), .rst(rst), .rx_serial(rx_serial),
    .cfg_cycles_per_bit(cfg_cycles_per_bit), .cfg_data_bits(cfg_data_bits),
    .cfg_msb_first(cfg_msb_first), .cfg_parity_mode(cfg_parity_mode),
    .cfg_parity_check(cfg_parity_check),
    .rx_data(rx_data), .rx_valid(rx_valid), .err_start(err_start),
    .err_parity(err_parity), .err_frame(err_frame)
  );

  int checks = 0;
  int errors = 0;
  int cycle_no = 0;
  int nval = 0;
  int cap_cycle = 0;
  logic [8:0] cap_data = '0;
  logic cap_es = 0, cap_ep = 0, cap_ef = 0;
  bit  done = 0;

  always @(posedge clk) cycle_no <= cycle_no + 1;

  always @(negedge clk) begin
    if (rx_valid) begin
      nval++;
      cap_cycle = cycle_no;
      cap_data  = rx_data;
      cap_es    = err_start;
      cap_ep    = err_parity;
      cap_ef    = err_frame;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [15:0] cpb;
    logic [3:0]  nb;
    logic        msb;
    logic [2:0]  mode;
    logic        chk;
    logic [8:0]  data;
    logic        sbad;
    logic        pflip;
    logic        fbad;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t TBL [NV] = '{
    '{16'd16, 4'd8, 1'b0, 3'd0, 1'b1, 9'h0A5, 1'b0, 1'b0, 1'b0},
    '{16'd16, 4'd8, 1'b1, 3'd2, 1'b1, 9'h03C, 1'b0, 1'b0, 1'b0},
    '{16'd20, 4'd7, 1'b0, 3'd1, 1'b1, 9'h055, 1'b0, 1'b1, 1'b0},
    '{16'd16, 4'd5, 1'b1, 3'd3, 1'b1, 9'h013, 1'b0, 1'b0, 1'b0},
    '{16'd12, 4'd9, 1'b0, 3'd4, 1'b1, 9'h1A7, 1'b0, 1'b0, 1'b0},
    '{16'd16, 4'd6, 1'b0, 3'd1, 1'b0, 9'h02D, 1'b0, 1'b1, 1'b0},
    '{16'd16, 4'd8, 1'b0, 3'd0, 1'b1, 9'h081, 1'b1, 1'b0, 1'b0},
    '{16'd16, 4'd8, 1'b0, 3'd2, 1'b1, 9'h0F0, 1'b0, 1'b0, 1'b1},
    '{16'd10, 4'd9, 1'b1, 3'd2, 1'b1, 9'h155, 1'b0, 1'b0, 1'b0},
    '{16'd15, 4'd8, 1'b0, 3'd0, 1'b1, 9'h000, 1'b0, 1'b0, 1'b0},
    '{16'd16, 4'd8, 1'b0, 3'd3, 1'b1, 9'h0C3, 1'b0, 1'b1, 1'b0}
  };

  // Drives one frame; bit values come only from the arguments.
  task automatic send_frame(input int cpb, input int nb, input bit msb, input logic [2:0] mode,
                            input logic [8:0] data, input bit sbad, input bit pflip,
                            input bit fbad, output int t0);
    logic bits [0:11];
    int   len;
    logic pb;
    bits[0] = 1'b0;
    for (int k = 0; k < nb; k++) bits[1+k] = data[msb ? nb-1-k : k];
    len = nb + 1;
    if (mode >= 3'd1 && mode <= 3'd4) begin
      case (mode)
        3'd1:    pb = ~^(data & ((9'h1 << nb) - 9'h1));
        3'd2:    pb = ^(data & ((9'h1 << nb) - 9'h1));
        3'd3:    pb = 1'b0;
        default: pb = 1'b1;
      endcase
      bits[len] = pb ^ pflip;
      len++;
    end
    bits[len] = !fbad;
    len++;
    @(negedge clk);
    t0 = cycle_no;
    for (int b = 0; b < len; b++) begin
      for (int i = 0; i < cpb; i++) begin
        if (b == 0 && sbad && i >= cpb/4) rx_serial = 1'b1;
        else                               rx_serial = bits[b];
        @(negedge clk);
      end
    end
    rx_serial = 1'b1;
    repeat (3*cpb) @(negedge clk);
  endtask

  task automatic run_vec(input vec_t v, input string tag);
    int t0, slots, lat;
    logic [8:0] exp_d;
    cfg_cycles_per_bit = v.cpb;
    cfg_data_bits      = v.nb;
    cfg_msb_first      = v.msb;
    cfg_parity_mode    = v.mode;
    cfg_parity_check   = v.chk;
    nval = 0;
    send_frame(int'(v.cpb), int'(v.nb), v.msb, v.mode, v.data, v.sbad, v.pflip, v.fbad, t0);
    exp_d = v.data & ((9'h1 << v.nb) - 9'h1);
    slots = int'(v.nb) + 1 + ((v.mode != 3'd0) ? 1 : 0);
    lat   = 3 + int'(v.cpb)/2 + slots*int'(v.cpb);
    chk({tag, " R12 one strobe"}, nval, 1);
    chk({tag, " R4 R5 data"}, cap_data, exp_d);
    chk({tag, " R3 R7 latency"}, cap_cycle - t0, lat);
    chk({tag, " R8 err_start"}, cap_es, v.sbad);
    chk({tag, " R6 R10 err_parity"}, cap_ep, (v.pflip && v.chk && v.mode != 0));
    chk({tag, " R9 err_frame"}, cap_ef, v.fbad);
  endtask

  initial begin
    int t0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 rx_valid", rx_valid, 0);
    chk("R1 rx_data", rx_data, 0);
    chk("R1 flags", {err_start, err_parity, err_frame}, 0);
    nval = 0;
    repeat (200) @(negedge clk);
    chk("R1 R2 idle high no strobe", nval, 0);

    for (int i = 0; i < NV; i++) run_vec(TBL[i], $sformatf("vec%0d", i));

    // R11: mid-frame configuration change is ignored
    cfg_cycles_per_bit = 16'd16; cfg_data_bits = 4'd8; cfg_msb_first = 1'b0;
    cfg_parity_mode = 3'd0; cfg_parity_check = 1'b1;
    nval = 0;
    fork
      send_frame(16, 8, 1'b0, 3'd0, 9'h0B6, 1'b0, 1'b0, 1'b0, t0);
      begin
        repeat (30) @(negedge clk);
        cfg_data_bits = 4'd5; cfg_msb_first = 1'b1; cfg_parity_mode = 3'd2;
      end
    join
    chk("R11 data", cap_data, 9'h0B6);
    chk("R11 latency", cap_cycle - t0, 3 + 8 + 9*16);
    chk("R11 one strobe", nval, 1);

    // R12: outputs cleared after the strobe
    chk("R12 valid low after", rx_valid, 0);
    chk("R12 flags low after", {err_start, err_parity, err_frame}, 0);

    // R1: reset returns outputs to zero after activity
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 data after reset", rx_data, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule